// File: doc/BRIEF.md
# Interrupt Entry and Return Frame Sequencer

This controller sits inside an 8-bit CPU core and performs the hardware steps of taking an interrupt and coming back from it. When a request passes the enable and priority test, the controller moves the stack pointer down by six. It then stores a six-byte frame through a byte-wide data-memory port, one byte per cycle. The frame holds the 16-bit auxiliary address register, the 19-bit return program counter packed into three bytes, and the status byte. After the frame is stored, the controller writes the accepted level into the status byte's mask field. It then reads a 16-bit handler address from a vector table and loads it into the program counter.

A return request reads the six bytes back from the lowest address upward. In a single cycle it then restores the status byte, the program counter and the auxiliary register, and moves the stack pointer up by six. The core's register file keeps ownership of SP, PC, status and the auxiliary register. The controller reads their current values and hands back new values through write-enable strobes. General data and address registers are never touched.

Top module: `irq_frame_seq`

## Requirements
- R1: While idle, a request is granted (`irq_ack_o` high for that cycle) only when `mie_i` is 1 and `irq_lvl_i` is numerically below the mask field, status bits [6:4]. A lower value means a higher priority. An equal or higher level, or `mie_i` at 0, is refused, and a refused request leaves SP untouched and causes no memory write.
- R2: In the cycle after a grant, `sp_we_o` is high with `sp_o` equal to the old SP minus 6. This happens before any frame byte is written, and SP is written exactly once during entry.
- R3: The frame is written with new SP as base, one byte per cycle, in this address order: SP+5 gets aux[15:8], SP+4 gets aux[7:0], SP+3 gets {pc[18], pc[17], 5'b0, pc[0]}, SP+2 gets pc[16:9], SP+1 gets pc[8:1], and SP gets the status byte as it was before the update.
- R4: After the frame is written, the status byte is written back with bits [6:4] set to the accepted level and every other bit unchanged.
- R5: The handler address is read as a low byte at base + 2·vector and a high byte at the next address. It is zero-extended to 19 bits and loaded into the PC.
- R6: `busy_o` is high from the cycle after the grant through the PC-load cycle, which is 9 cycles for an entry.
- R7: No grant occurs while busy. A request that is still pending when busy falls is judged at once against the updated mask, which lets a higher-priority request nest.
- R8: With `reti_i` high while idle, the controller reads SP, SP+1, …, SP+5 in consecutive cycles. It then restores status, PC and aux register and sets SP to SP+6, all in one cycle, so busy lasts 7 cycles.
- R9: If `reti_i` and a grantable request arrive in the same idle cycle, the return is performed and no grant is given.
- R10: The memory strobes are low whenever the block is idle, a read and a write never occur in the same cycle, and an entry performs exactly six writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request, held by the source |
| irq_lvl_i | input | LVL_W | Level of the pending request |
| irq_vec_i | input | VEC_W | Vector number of the pending request |
| mie_i | input | 1 | Master interrupt enable |
| reti_i | input | 1 | Start the return sequence |
| vec_base_i | input | ADDR_W | Vector table base address |
| sp_i | input | ADDR_W | Current stack pointer |
| pc_i | input | 19 | Return program counter |
| psw_i | input | 8 | Current status byte |
| ha_i | input | 16 | Current auxiliary address register |
| irq_ack_o | output | 1 | Request granted this cycle |
| busy_o | output | 1 | Sequence in progress |
| mem_addr_o | output | ADDR_W | Data memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle |
| sp_o | output | ADDR_W | New stack pointer |
| sp_we_o | output | 1 | Stack pointer write |
| pc_o | output | 19 | New program counter |
| pc_we_o | output | 1 | Program counter write |
| psw_o | output | 8 | New status byte |
| psw_we_o | output | 1 | Status byte write |
| ha_o | output | 16 | Restored auxiliary register |
| ha_we_o | output | 1 | Auxiliary register write |

## Verification
The bound checker verifies the following on every cycle:
- a grant respects the enable and the mask;
- the stack pointer drop follows a grant directly, with no memory write in that cycle;
- busy rises after a grant and falls after the PC load;
- no grant is issued while busy;
- the memory strobes stay quiet and exclusive when the block is idle.

Only the bench's scenarios can show the remaining behaviour. This covers the byte placement and write order of the frame, the packing of PC bits 18, 17 and 0, the masked status update and the vector fetch. It also covers the full round trip through the return sequence, nesting of a higher-priority request that waits through a busy period, and return winning over a simultaneous request.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  localparam int PC_W = 19;
  localparam int HA_W = 16;
  localparam int FRAME_BYTES = 6;

  typedef enum logic [4:0] {
    S_IDLE, S_SPDEC,
    S_W5, S_W4, S_W3, S_W2, S_W1, S_W0,
    S_V0, S_V1,
    S_R0, S_R1, S_R2, S_R3, S_R4, S_R5, S_RFIN
  } seq_state_e;

  // pc bits 18,17 in the top two bits, bit 0 in the lowest
  function automatic logic [7:0] pc_hi_byte(input logic [PC_W-1:0] pc);
    return {pc[18], pc[17], 5'b0, pc[0]};
  endfunction
endpackage

// File: rtl/ifs_gate.sv
module ifs_gate #(
  parameter int LVL_W  = 3,
  parameter int IM_LSB = 4
) (
  input  logic             idle_i,
  input  logic             req_i,
  input  logic             mie_i,
  input  logic             reti_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [7:0]       psw_i,
  output logic             grant_o,
  output logic             ret_go_o
);
  logic [LVL_W-1:0] im;
  assign im       = psw_i[IM_LSB +: LVL_W];
  assign ret_go_o = idle_i && reti_i;
  // return wins over a simultaneous request
  assign grant_o  = idle_i && !reti_i && req_i && mie_i && (lvl_i < im);
endmodule

// File: rtl/ifs_addr.sv
module ifs_addr
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 5
) (
  input  seq_state_e        state_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              re_o
);
  logic [ADDR_W-1:0] vec_off;
  assign vec_off = ADDR_W'({vec_i, 1'b0});

  always_comb begin
    addr_o = sp_i;
    we_o   = 1'b0;
    re_o   = 1'b0;
    unique case (state_i)
      S_W5: begin addr_o = sp_i + ADDR_W'(5); we_o = 1'b1; end
      S_W4: begin addr_o = sp_i + ADDR_W'(4); we_o = 1'b1; end
      S_W3: begin addr_o = sp_i + ADDR_W'(3); we_o = 1'b1; end
      S_W2: begin addr_o = sp_i + ADDR_W'(2); we_o = 1'b1; end
      S_W1: begin addr_o = sp_i + ADDR_W'(1); we_o = 1'b1; end
      S_W0: begin addr_o = sp_i;              we_o = 1'b1; end
      S_V0: begin addr_o = base_i + vec_off;              re_o = 1'b1; end
      S_V1: begin addr_o = base_i + vec_off + ADDR_W'(1); re_o = 1'b1; end
      S_R0: begin addr_o = sp_i;              re_o = 1'b1; end
      S_R1: begin addr_o = sp_i + ADDR_W'(1); re_o = 1'b1; end
      S_R2: begin addr_o = sp_i + ADDR_W'(2); re_o = 1'b1; end
      S_R3: begin addr_o = sp_i + ADDR_W'(3); re_o = 1'b1; end
      S_R4: begin addr_o = sp_i + ADDR_W'(4); re_o = 1'b1; end
      S_R5: begin addr_o = sp_i + ADDR_W'(5); re_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import ifs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 5,
  parameter int IM_LSB = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [VEC_W-1:0]  irq_vec_i,
  input  logic              mie_i,
  input  logic              reti_i,
  input  logic [ADDR_W-1:0] vec_base_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [18:0]       pc_i,
  input  logic [7:0]        psw_i,
  input  logic [15:0]       ha_i,
  output logic              irq_ack_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic              sp_we_o,
  output logic [18:0]       pc_o,
  output logic              pc_we_o,
  output logic [7:0]        psw_o,
  output logic              psw_we_o,
  output logic [15:0]       ha_o,
  output logic              ha_we_o
);
  localparam logic [ADDR_W-1:0] FRAME = ADDR_W'(FRAME_BYTES);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] sp_q;
  logic [HA_W-1:0]   ha_q;
  logic [PC_W-1:0]   pc_q;
  logic [7:0]        psw_q, vlo_q, psw_im;
  logic [LVL_W-1:0]  lvl_q;
  logic [VEC_W-1:0]  vec_q;
  logic              idle, grant, ret_go;

  assign idle = (state_q == S_IDLE);

  ifs_gate #(.LVL_W(LVL_W), .IM_LSB(IM_LSB)) u_gate (
    .idle_i  (idle),
    .req_i   (irq_req_i),
    .mie_i   (mie_i),
    .reti_i  (reti_i),
    .lvl_i   (irq_lvl_i),
    .psw_i   (psw_i),
    .grant_o (grant),
    .ret_go_o(ret_go)
  );

  ifs_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_addr (
    .state_i(state_q),
    .sp_i   (sp_q),
    .vec_i  (vec_q),
    .base_i (vec_base_i),
    .addr_o (mem_addr_o),
    .we_o   (mem_we_o),
    .re_o   (mem_re_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sp_q    <= '0;
      ha_q    <= '0;
      pc_q    <= '0;
      psw_q   <= '0;
      vlo_q   <= '0;
      lvl_q   <= '0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (grant) begin
            sp_q    <= sp_i;
            ha_q    <= ha_i;
            pc_q    <= pc_i;
            psw_q   <= psw_i;
            lvl_q   <= irq_lvl_i;
            vec_q   <= irq_vec_i;
            state_q <= S_SPDEC;
          end else if (ret_go) begin
            sp_q    <= sp_i;
            state_q <= S_R0;
          end
        end
        S_SPDEC: begin sp_q <= sp_q - FRAME; state_q <= S_W5; end
        S_W5: state_q <= S_W4;
        S_W4: state_q <= S_W3;
        S_W3: state_q <= S_W2;
        S_W2: state_q <= S_W1;
        S_W1: state_q <= S_W0;
        S_W0: state_q <= S_V0;
        S_V0: begin vlo_q <= mem_rdata_i; state_q <= S_V1; end
        S_V1: state_q <= S_IDLE;
        S_R0: begin psw_q <= mem_rdata_i; state_q <= S_R1; end
        S_R1: begin pc_q[8:1] <= mem_rdata_i; state_q <= S_R2; end
        S_R2: begin pc_q[16:9] <= mem_rdata_i; state_q <= S_R3; end
        S_R3: begin
          pc_q[18:17] <= mem_rdata_i[7:6];
          pc_q[0]     <= mem_rdata_i[0];
          state_q     <= S_R4;
        end
        S_R4: begin ha_q[7:0] <= mem_rdata_i; state_q <= S_R5; end
        S_R5: begin ha_q[15:8] <= mem_rdata_i; state_q <= S_RFIN; end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    psw_im = psw_q;
    psw_im[IM_LSB +: LVL_W] = lvl_q;
  end

  always_comb begin
    unique case (state_q)
      S_W5:    mem_wdata_o = ha_q[15:8];
      S_W4:    mem_wdata_o = ha_q[7:0];
      S_W3:    mem_wdata_o = pc_hi_byte(pc_q);
      S_W2:    mem_wdata_o = pc_q[16:9];
      S_W1:    mem_wdata_o = pc_q[8:1];
      S_W0:    mem_wdata_o = psw_q;
      default: mem_wdata_o = '0;
    endcase
  end

  assign irq_ack_o = grant;
  assign busy_o    = !idle;
  assign sp_we_o   = (state_q == S_SPDEC) || (state_q == S_RFIN);
  assign sp_o      = (state_q == S_SPDEC) ? sp_q - FRAME : sp_q + FRAME;
  assign psw_we_o  = (state_q == S_V0) || (state_q == S_RFIN);
  assign psw_o     = (state_q == S_V0) ? psw_im : psw_q;
  assign pc_we_o   = (state_q == S_V1) || (state_q == S_RFIN);
  assign pc_o      = (state_q == S_V1) ? PC_W'({mem_rdata_i, vlo_q}) : pc_q;
  assign ha_we_o   = (state_q == S_RFIN);
  assign ha_o      = ha_q;
endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
  parameter int ADDR_W = 16,
  parameter int LVL_W  = 3,
  parameter int IM_LSB = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_req_i,
  input logic [LVL_W-1:0]  irq_lvl_i,
  input logic              mie_i,
  input logic [7:0]        psw_i,
  input logic [ADDR_W-1:0] sp_i,
  input logic              irq_ack_o,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              sp_we_o,
  input logic              pc_we_o
);
  // R1
  grant_rule_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> irq_req_i && mie_i && (irq_lvl_i < psw_i[IM_LSB +: LVL_W]));
  // R2
  sp_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> sp_we_o && !mem_we_o && (sp_o == $past(sp_i) - ADDR_W'(6)));
  // R6
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> busy_o);
  // R6
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> !busy_o);
  // R7
  no_ack_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_ack_o);
  // R10
  mem_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> busy_o);
  // R10
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind irq_frame_seq ifs_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .IM_LSB(IM_LSB)) u_ifs_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_req_i(irq_req_i),
  .irq_lvl_i(irq_lvl_i),
  .mie_i    (mie_i),
  .psw_i    (psw_i),
  .sp_i     (sp_i),
  .irq_ack_o(irq_ack_o),
  .busy_o   (busy_o),
  .mem_we_o (mem_we_o),
  .mem_re_o (mem_re_o),
  .sp_o     (sp_o),
  .sp_we_o  (sp_we_o),
  .pc_we_o  (pc_we_o)
);

// File: tb/irq_frame_seq_bench.sv
module irq_frame_seq_bench;
  typedef struct packed {
    logic [15:0] sp;
    logic [15:0] ha;
    logic [18:0] pc;
    logic [7:0]  psw;
    logic [2:0]  lvl;
    logic [4:0]  vec;
    logic        mie;
    logic        acc;
  } row_t;

  localparam int NROW = 6;
  localparam row_t TBL [NROW] = '{
    '{16'h00F0, 16'hBEEF, 19'h7A5C3, 8'h7F, 3'd2, 5'd3,  1'b1, 1'b1},
    '{16'h0060, 16'h1234, 19'h50001, 8'hA5, 3'd1, 5'd0,  1'b1, 1'b1},
    '{16'h0060, 16'h0000, 19'h12345, 8'h25, 3'd2, 5'd4,  1'b1, 1'b0},
    '{16'h0080, 16'h0001, 19'h00010, 8'h70, 3'd0, 5'd5,  1'b0, 1'b0},
    '{16'h0050, 16'hFFFF, 19'h7FFFF, 8'h70, 3'd6, 5'd31, 1'b1, 1'b1},
    '{16'h00A0, 16'h00FF, 19'h00000, 8'h10, 3'd0, 5'd17, 1'b1, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic irq_req = 1'b0, mie = 1'b0, reti = 1'b0;
  logic [2:0] lvl = '0;
  logic [4:0] vec = '0;
  logic ack, busy, mwe, mre, spwe, pcwe, pswwe, hawe;
  logic [15:0] maddr, spo, hao;
  logic [7:0] mwd, mrd, pswo;
  logic [18:0] pco;

  logic        ld = 1'b0;
  logic [15:0] ld_sp = '0, ld_ha = '0;
  logic [18:0] ld_pc = '0;
  logic [7:0]  ld_psw = '0;
  logic [15:0] cpu_sp, cpu_ha;
  logic [18:0] cpu_pc;
  logic [7:0]  cpu_psw;

  logic [7:0]  mem [256];
  logic [15:0] wlog [8];
  int          wspc [8];
  int          wr_cnt, spw_cnt, idle_acc;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_frame_seq u_irq_frame_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_req_i(irq_req), .irq_lvl_i(lvl),
    .irq_vec_i(vec), .mie_i(mie), .reti_i(reti), .vec_base_i(16'h0000),
    .sp_i(cpu_sp), .pc_i(cpu_pc), .psw_i(cpu_psw), .ha_i(cpu_ha),
    .irq_ack_o(ack), .busy_o(busy), .mem_addr_o(maddr), .mem_wdata_o(mwd),
    .mem_we_o(mwe), .mem_re_o(mre), .mem_rdata_i(mrd),
    .sp_o(spo), .sp_we_o(spwe), .pc_o(pco), .pc_we_o(pcwe),
    .psw_o(pswo), .psw_we_o(pswwe), .ha_o(hao), .ha_we_o(hawe)
  );

  function automatic logic [15:0] vec_word(input int v);
    return {8'h80 | 8'(v), 8'(v * 7 + 1)};
  endfunction

  assign mrd = mem[maddr[7:0]];

  // core register file and data memory model
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_sp <= '0; cpu_ha <= '0; cpu_pc <= '0; cpu_psw <= '0;
      wr_cnt <= 0; spw_cnt <= 0; idle_acc <= 0;
      for (int a = 0; a < 256; a++) mem[a] <= '0;
      for (int v = 0; v < 32; v++) begin
        mem[2*v]     <= vec_word(v)[7:0];
        mem[2*v + 1] <= vec_word(v)[15:8];
      end
      for (int k = 0; k < 8; k++) begin wlog[k] <= '0; wspc[k] <= 0; end
    end else begin
      if (ld) begin
        cpu_sp <= ld_sp; cpu_ha <= ld_ha; cpu_pc <= ld_pc; cpu_psw <= ld_psw;
      end else begin
        if (spwe)  cpu_sp  <= spo;
        if (pcwe)  cpu_pc  <= pco;
        if (pswwe) cpu_psw <= pswo;
        if (hawe)  cpu_ha  <= hao;
      end
      if (spwe) spw_cnt <= spw_cnt + 1;
      if (mwe) begin
        mem[maddr[7:0]]   <= mwd;
        wlog[wr_cnt % 8]  <= maddr;
        wspc[wr_cnt % 8]  <= spw_cnt;
        wr_cnt            <= wr_cnt + 1;
      end
      if ((mwe || mre) && !busy) idle_acc <= idle_acc + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_cpu(input logic [15:0] sp, input logic [15:0] ha,
                          input logic [18:0] pc, input logic [7:0] psw);
    @(negedge clk_i);
    ld = 1'b1; ld_sp = sp; ld_ha = ha; ld_pc = pc; ld_psw = psw;
    @(negedge clk_i);
    ld = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk_i); end
  endtask

  task automatic do_reti_check(input logic [15:0] sp, input logic [15:0] ha,
                               input logic [18:0] pc, input logic [7:0] psw);
    int n;
    reti = 1'b1;
    @(negedge clk_i);
    reti = 1'b0;
    wait_busy(n);
    chk(n == 7, "R8 return busy cycles", n, 7);
    chk(cpu_sp == sp, "R8 sp restored", cpu_sp, sp);
    chk(cpu_pc == pc, "R8 pc restored", cpu_pc, pc);
    chk(cpu_ha == ha, "R8 aux restored", cpu_ha, ha);
    chk(cpu_psw == psw, "R8 status restored", cpu_psw, psw);
  endtask

  task automatic do_row(input int i);
    row_t r;
    int n, wb, sb;
    logic [15:0] spn;
    logic [7:0] exp_psw;
    r = TBL[i];
    load_cpu(r.sp, r.ha, r.pc, r.psw);
    mie = r.mie; lvl = r.lvl; vec = r.vec; irq_req = 1'b1;
    wb = wr_cnt; sb = spw_cnt;
    #1;
    chk(ack == r.acc, "R1 grant decision", ack, r.acc);
    @(negedge clk_i);
    if (!r.acc) begin
      repeat (2) begin
        chk(!busy, "R1 refused stays idle", busy, 0);
        @(negedge clk_i);
      end
      irq_req = 1'b0;
      chk(cpu_sp == r.sp, "R1 refused sp kept", cpu_sp, r.sp);
      chk(wr_cnt == wb, "R1 refused no write", wr_cnt - wb, 0);
    end else begin
      irq_req = 1'b0;
      wait_busy(n);
      spn = r.sp - 16'd6;
      chk(n == 9, "R6 entry busy cycles", n, 9);
      chk(cpu_sp == spn, "R2 sp lowered", cpu_sp, spn);
      chk(wspc[wb % 8] == sb + 1, "R2 sp before first write", wspc[wb % 8], sb + 1);
      chk(wr_cnt - wb == 6, "R10 six writes", wr_cnt - wb, 6);
      for (int k = 0; k < 6; k++)
        chk(wlog[(wb + k) % 8] == spn + 16'(5 - k), "R3 write order",
            wlog[(wb + k) % 8], spn + 16'(5 - k));
      chk(mem[spn[7:0] + 8'd5] == r.ha[15:8], "R3 aux high", mem[spn[7:0] + 8'd5], r.ha[15:8]);
      chk(mem[spn[7:0] + 8'd4] == r.ha[7:0], "R3 aux low", mem[spn[7:0] + 8'd4], r.ha[7:0]);
      chk(mem[spn[7:0] + 8'd3] == {r.pc[18:17], 5'b0, r.pc[0]}, "R3 pc packed",
          mem[spn[7:0] + 8'd3], {r.pc[18:17], 5'b0, r.pc[0]});
      chk(mem[spn[7:0] + 8'd2] == r.pc[16:9], "R3 pc mid", mem[spn[7:0] + 8'd2], r.pc[16:9]);
      chk(mem[spn[7:0] + 8'd1] == r.pc[8:1], "R3 pc low", mem[spn[7:0] + 8'd1], r.pc[8:1]);
      chk(mem[spn[7:0]] == r.psw, "R3 status saved", mem[spn[7:0]], r.psw);
      exp_psw = (r.psw & 8'h8F) | {1'b0, r.lvl, 4'b0};
      chk(cpu_psw == exp_psw, "R4 mask updated", cpu_psw, exp_psw);
      chk(cpu_pc == {3'b0, vec_word(r.vec)}, "R5 handler pc", cpu_pc, {3'b0, vec_word(r.vec)});
      do_reti_check(r.sp, r.ha, r.pc, r.psw);
    end
  endtask

  initial begin
    int n;
    bit seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy && !mwe && !mre && !spwe && !ack, "R6 reset idle",
        {busy, mwe, mre, spwe, ack}, 0);

    for (int i = 0; i < NROW; i++) do_row(i);

    // R7: higher-priority request waits through busy then nests
    load_cpu(16'h00F0, 16'h4321, 19'h2ABCD, 8'h70);
    mie = 1'b1; lvl = 3'd5; vec = 5'd1; irq_req = 1'b1;
    #1;
    chk(ack, "R7 first grant", ack, 1);
    @(negedge clk_i);
    lvl = 3'd2; vec = 5'd2;
    seen = 1'b0;
    while (busy) begin
      if (ack) seen = 1'b1;
      @(negedge clk_i);
    end
    chk(!seen, "R7 no grant while busy", seen, 0);
    #1;
    chk(ack, "R7 pending granted after busy", ack, 1);
    @(negedge clk_i);
    irq_req = 1'b0;
    wait_busy(n);
    chk(cpu_sp == 16'h00E4, "R7 nested sp", cpu_sp, 16'h00E4);
    chk(cpu_pc == {3'b0, vec_word(2)}, "R7 nested pc", cpu_pc, {3'b0, vec_word(2)});
    chk(cpu_psw == 8'h20, "R7 nested mask", cpu_psw, 8'h20);
    do_reti_check(16'h00EA, 16'h4321, {3'b0, vec_word(1)}, 8'h50);
    do_reti_check(16'h00F0, 16'h4321, 19'h2ABCD, 8'h70);

    // R9: return wins over a simultaneous grantable request
    @(negedge clk_i);
    lvl = 3'd1; vec = 5'd3; irq_req = 1'b1; reti = 1'b1;
    #1;
    chk(!ack, "R9 no grant with return", ack, 0);
    @(negedge clk_i);
    reti = 1'b0; irq_req = 1'b0;
    wait_busy(n);
    chk(n == 7, "R9 return ran", n, 7);
    chk(cpu_sp == 16'h00F6, "R9 sp raised", cpu_sp, 16'h00F6);

    chk(idle_acc == 0, "R10 idle memory quiet", idle_acc, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule